// File: doc/BRIEF.md
# Thread-Owned Hardware Lock Bank

This block is a small bank of hardware locks that several logical CPUs of a time-sliced core share. Each entry is one 32-bit word. Bits [31:16] hold the identifier of the thread that owns the entry, and bits [15:0] hold data that belongs to the owner. An owner field of zero means the entry is free.

A write carries the requesting thread's identifier on a separate input. It is accepted only when the entry is free or already belongs to that thread. A thread claims a lock by writing its own identifier into the owner field. It releases the lock by writing zero there. The accept result is returned combinationally in the same cycle as the request. Reads are unconditional and return the whole word one cycle later.

Only one access arrives per cycle, because the logical CPUs take turns on the clock. Arbitration, coherence and software layers built on top of the bank lie outside the block.

Top module: `thread_lock_bank`

## Requirements
- R1: After a synchronous active-low reset every entry holds zero, `rd_data` is zero and `wr_ok` is low.
- R2: An entry is laid out as owner in bits [31:16] and data in bits [15:0]. An accepted write stores the whole 32-bit `acc_wdata` word into the addressed entry, including the last entry (index ENTRIES-1).
- R3: A write is accepted, with `wr_ok` high in the same cycle, when all of these hold: the stored owner is zero or equals `acc_tid`; `acc_tid` is non-zero; and `acc_wdata[31:16]` is zero or equals `acc_tid`.
- R4: A rejected write leaves the entry unchanged and drives `wr_ok` low in the same cycle.
- R5: A request with `acc_tid` equal to zero is always rejected, whether the entry is free or owned.
- R6: A write whose new owner field is neither zero nor `acc_tid` is rejected, so a lock cannot be handed to another thread.
- R7: The owner releases a lock by writing zero into the owner field. After that, a different thread can claim the entry.
- R8: `rd_data` in the cycle after an address is presented equals the entry as it stood before any write in that same cycle.
- R9: An address at or above ENTRIES reads as zero, is never accepted for writing, and leaves all entries unchanged.
- R10: `wr_ok` is low whenever `acc_wr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_addr | input | ADDR_W (8) | Entry address |
| acc_wr | input | 1 | Write request |
| acc_tid | input | 16 | Identifier of the requesting thread |
| acc_wdata | input | 32 | New entry word: owner [31:16], data [15:0] |
| wr_ok | output | 1 | Write accepted (combinational, same cycle) |
| rd_data | output | 32 | Entry word read, one cycle after the address |

## Verification
The bench attacks the acceptance rule from every side:
- A foreign thread writing an owned entry. A gate that compares only against zero would let that thread overwrite the owner.
- Thread zero writing a free entry. A design that treats the zero identifier as an ordinary owner would accept it.
- A write that tries to hand the lock to a third thread. This would be silently accepted if the new owner field went unchecked.

It releases a lock and reclaims it with a different identifier. It reads an entry in the same cycle as a write to it, which would expose a read path that bypasses the register. It probes address 64 and higher, where truncated index decoding would alias onto entry 0 and corrupt it.

// File: rtl/lock_pkg.sv
// Shared widths and entry type for the thread-owned lock bank.
// Assumes a 16-bit owner field above a 16-bit data field.
package lock_pkg;
    localparam int OWN_W  = 16;
    localparam int DAT_W  = 16;
    localparam int WORD_W = OWN_W + DAT_W;

    typedef logic [OWN_W-1:0] tid_t;

    typedef struct packed {
        tid_t             owner;
        logic [DAT_W-1:0] data;
    } lock_word_t;

    // True when a lock currently held by 'held' may be written by 'req'.
    function automatic logic holder_permits(tid_t held, tid_t req);
        return (held == '0) || (held == req);
    endfunction
endpackage

// File: rtl/lock_gate.sv
// Acceptance decision for one write request.
// Assumes the stored word is already selected by the caller and that
// identifier zero is reserved to mean "free".
module lock_gate
    import lock_pkg::*;
(
    input  logic wr,
    input  logic in_range,
    input  tid_t held,
    input  tid_t req,
    input  tid_t new_owner,
    output logic accept
);
    logic id_valid;
    logic holder_ok;
    logic pass_ok;

    // Combine the ownership conditions into the accept flag.
    always_comb begin
        id_valid  = (req != '0);
        holder_ok = holder_permits(held, req);
        pass_ok   = (new_owner == '0) || (new_owner == req);
        accept    = wr && in_range && id_valid && holder_ok && pass_ok;
    end
endmodule

// File: rtl/lock_store.sv
// Storage for ENTRIES lock words, one register per entry with its own
// write enable, plus a combinational read of the selected entry.
// Assumes at most one write per cycle; the index may exceed ENTRIES-1 when
// ENTRIES is not a power of two, in which case the read returns zero.
module lock_store
    import lock_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  lock_word_t       wword,
    output lock_word_t       cur
);
    lock_word_t mem [ENTRIES];

    for (genvar k = 0; k < ENTRIES; k++) begin : g_entry
        // Hold or update entry k.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[k] <= '0;
            else if (we && (idx == IDX_W'(k)))
                mem[k] <= wword;
        end

        // R4: an entry with no write enable aimed at it keeps its value.
        a_r4_entry_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && (idx == IDX_W'(k))) |=> $stable(mem[k]));
    end

    // Select the addressed entry for the gate and the read path.
    always_comb begin
        if ({1'b0, idx} < (IDX_W+1)'(ENTRIES))
            cur = mem[idx];
        else
            cur = '0;
    end
endmodule

// File: rtl/lock_readout.sv
// One-cycle registered read port; out-of-range addresses return zero.
// Assumes 'cur' is the entry value before any same-cycle write.
module lock_readout
    import lock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_range,
    input  lock_word_t        cur,
    output logic [WORD_W-1:0] rd
);
    // Register the selected word, or zero for an unmapped address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd <= '0;
        else
            rd <= in_range ? cur : '0;
    end

    // R9: an unmapped address seen last cycle reads as zero now.
    a_r9_oob_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!in_range) |-> (rd == '0));
endmodule

// File: rtl/thread_lock_bank.sv
// Bank of thread-owned hardware locks with a single-cycle access port.
// Assumes one access per cycle from a time-sliced core; wr_ok is
// combinational from the request, and reads have one cycle of latency.
module thread_lock_bank
    import lock_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_wr,
    input  logic [OWN_W-1:0]  acc_tid,
    input  logic [WORD_W-1:0] acc_wdata,
    output logic              wr_ok,
    output logic [WORD_W-1:0] rd_data
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic             in_range;
    logic [IDX_W-1:0] idx;
    lock_word_t       cur;
    lock_word_t       wword;

    // Decode the address into a range flag and an entry index.
    always_comb begin
        in_range = ({1'b0, acc_addr} < (ADDR_W+1)'(ENTRIES));
        idx      = acc_addr[IDX_W-1:0];
        wword    = lock_word_t'(acc_wdata);
    end

    lock_gate u_gate (
        .wr        (acc_wr),
        .in_range  (in_range),
        .held      (cur.owner),
        .req       (acc_tid),
        .new_owner (wword.owner),
        .accept    (wr_ok)
    );

    lock_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_ok),
        .idx   (idx),
        .wword (wword),
        .cur   (cur)
    );

    lock_readout u_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_range (in_range),
        .cur      (cur),
        .rd       (rd_data)
    );

    // R3: an accepted write always targets a free or self-owned entry.
    a_r3_owner_match: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |-> ((cur.owner == '0) || (cur.owner == acc_tid)));

    // R5: identifier zero is never accepted.
    a_r5_tid_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && (acc_tid == '0)) |-> !wr_ok);

    // R9: writes to unmapped addresses are refused.
    a_r9_oob_write: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && ({1'b0, acc_addr} >= (ADDR_W+1)'(ENTRIES))) |-> !wr_ok);

    // R10: no accept without a write request.
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_wr |-> !wr_ok);
endmodule

// File: tb/sim_thread_lock_bank.sv
`timescale 1ns/1ps
module sim_thread_lock_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  acc_addr = '0;
    logic        acc_wr = 1'b0;
    logic [15:0] acc_tid = '0;
    logic [31:0] acc_wdata = '0;
    logic        wr_ok;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] model [64];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    thread_lock_bank u0 (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wr(acc_wr),
        .acc_tid(acc_tid), .acc_wdata(acc_wdata), .wr_ok(wr_ok), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: present one access, check wr_ok, queue the expected read word.
    task automatic op(input logic [7:0] a, input bit w, input logic [15:0] tid,
                      input logic [31:0] wd, input string req);
        logic [31:0] held;
        bit ok;
        @(negedge clk);
        acc_addr = a; acc_wr = w; acc_tid = tid; acc_wdata = wd;
        held = (a < 8'd64) ? model[a[5:0]] : 32'h0;
        exp_q.push_back(held);
        tag_q.push_back(req);
        ok = w && (a < 8'd64) && (tid != 16'h0) &&
             (held[31:16] == 16'h0 || held[31:16] == tid) &&
             (wd[31:16] == 16'h0 || wd[31:16] == tid);
        #1;
        check(req, {31'b0, wr_ok}, {31'b0, ok});
        if (ok) model[a[5:0]] = wd;
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        op(a, 1'b0, 16'h0, 32'h0, req);
    endtask

    // Monitor: compare the registered read word against the queue.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, rd_data, e);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = 32'h0;
        repeat (4) @(posedge clk);
        #2;
        check("R1", rd_data, 32'h0);
        check("R1", {31'b0, wr_ok}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 64; i++) rd(8'(i), "R1");
        // Claim and update.
        op(8'd5, 1'b1, 16'h0003, 32'h0003_AAAA, "R3");
        rd(8'd5, "R2");
        op(8'd5, 1'b1, 16'h0003, 32'h0003_1234, "R3");
        // Foreign writer.
        op(8'd5, 1'b1, 16'h0007, 32'h0007_BEEF, "R4");
        rd(8'd5, "R4");
        // Thread zero.
        op(8'd5, 1'b1, 16'h0000, 32'h0000_FFFF, "R5");
        op(8'd9, 1'b1, 16'h0000, 32'h0000_1111, "R5");
        rd(8'd9, "R5");
        rd(8'd5, "R5");
        // Hand-off attempt.
        op(8'd9, 1'b1, 16'h0004, 32'h0006_2222, "R6");
        rd(8'd9, "R6");
        // Release and reclaim.
        op(8'd5, 1'b1, 16'h0003, 32'h0000_0042, "R7");
        rd(8'd5, "R7");
        op(8'd5, 1'b1, 16'h0007, 32'h0007_7777, "R7");
        rd(8'd5, "R7");
        // Same-cycle read sees the old word, next read sees the new one.
        op(8'd20, 1'b1, 16'h0002, 32'h0002_5555, "R8");
        rd(8'd20, "R8");
        op(8'd20, 1'b1, 16'h0002, 32'h0002_6666, "R8");
        rd(8'd20, "R8");
        // Last entry.
        op(8'd63, 1'b1, 16'h00FF, 32'h00FF_CAFE, "R2");
        rd(8'd63, "R2");
        // Unmapped addresses.
        op(8'd64, 1'b1, 16'h0001, 32'h0001_9999, "R9");
        rd(8'd64, "R9");
        rd(8'd0, "R9");
        op(8'd255, 1'b1, 16'h0001, 32'h0001_8888, "R9");
        rd(8'd255, "R9");
        rd(8'd63, "R9");
        // No write request.
        op(8'd5, 1'b0, 16'h0007, 32'h0007_0000, "R10");
        rd(8'd5, "R10");
        @(negedge clk);
        acc_wr = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule